// File: doc/BRIEF.md
# Block-Transfer DMA Engine for Expansion RAM

This block sits on a host processor's 8-bit register bus and moves bytes between host memory (16-bit address space) and a private expansion RAM of 128K, 256K or 512K bytes. Software programs a host base address, an expansion base address, a byte count and an address-control byte. It then writes a command byte, which either starts the transfer at once or arms it to wait for a host write to a trigger address. Four operations exist: host to expansion copy, expansion to host copy, byte swap between the two sides, and compare with abort on the first difference.

The sequencer has five named states. IDLE waits for a start. REQ raises the host bus request and waits for grant. FETCH issues the reads. STORE performs the writes or the comparison and advances the addresses. FIN writes the results back to the register file and releases the bus.

The transitions are as follows. IDLE goes to REQ on start. REQ goes to FETCH when grant is seen. FETCH always goes to STORE. STORE goes to FETCH while bytes remain, and goes to FIN after the last byte or on a compare mismatch. FIN always returns to IDLE. Each byte therefore takes two cycles once the bus is granted.

Top module: `xram_dma`

## Requirements
- R1: After reset, register 0 reads 0x50 with the default 512K configuration (0x40 when the RAM is 128K). Registers 1 to 5, 7 and 8 read 0x00. Register 6 reads 0xF8, register 9 reads 0x1F, register 10 reads 0x3F, and registers 11 to 15 read 0xFF.
- R2: Reading register 0 returns its full value. The same read then clears bits 7 to 5, and bit 4 (size above 128K) is kept.
- R3: Reads of register 6 force bits 7:3 to one, reads of register 9 force bits 4:0 to one, and reads of register 10 force bits 5:0 to one. Writes to register 0 and to registers 11 to 15 have no effect.
- R4: Writing register 1 with bits 7 and 4 both set starts a transfer, and `busy` is high in the following cycle. Command bits 1:0 select the operation: 0 copies host to expansion, 1 copies expansion to host, 2 swaps, 3 compares.
- R5: A command with bit 7 set and bit 4 clear does not start a transfer. The transfer starts on a `trig` pulse. A `trig` pulse with no armed command, or while busy, does nothing.
- R6: Operation 0 copies each host byte {reg3,reg2}+i to expansion address ({reg6,reg5,reg4}+i) masked to the RAM size.
- R7: Operation 1 copies each expansion byte into the matching host address.
- R8: Operation 2 exchanges the host and expansion bytes at each position.
- R9: Operation 3 compares the byte pairs. The first difference sets status bit 5 and ends the transfer, leaving both addresses on the differing byte. A full match leaves bit 5 clear.
- R10: Register 10 bit 7 set holds the host address fixed, and bit 6 set holds the expansion address fixed. A clear bit makes that address increment by one per byte.
- R11: A length {reg8,reg7} of 0 means 65536 bytes.
- R12: With command bit 5 clear, the end of a transfer writes the final host address into registers 2-3, the final expansion address into registers 4-6, and the remaining count into registers 7-8. With bit 5 set, those registers keep their programmed values.
- R13: When a transfer ends, status bit 6 is set, command bit 7 is cleared, and `busy` falls in the same cycle the flag becomes visible. Register writes made while busy are ignored.
- R14: `bus_req` stays high from the request until the transfer ends and is low whenever the block is idle. Host reads and writes happen only while `bus_gnt` is high, at most one per cycle, and read data returns one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status clear side effect) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| trig | input | 1 | Deferred-start pulse from a host trigger-address write |
| busy | output | 1 | Transfer in progress |
| bus_req | output | 1 | Host bus request |
| bus_gnt | input | 1 | Host bus grant |
| hb_addr | output | 16 | Host memory address |
| hb_re | output | 1 | Host read strobe |
| hb_we | output | 1 | Host write strobe |
| hb_wdata | output | 8 | Host write data |
| hb_rdata | input | 8 | Host read data, one cycle after hb_re |
| xr_addr | output | XRAM_AW | Expansion RAM address |
| xr_re | output | 1 | Expansion read strobe |
| xr_we | output | 1 | Expansion write strobe |
| xr_wdata | output | 8 | Expansion write data |
| xr_rdata | input | 8 | Expansion read data, one cycle after xr_re |

## Verification
Each of the four operations is driven with random bases, lengths and address-hold flags. Because host and expansion contents come from different seed functions, a copy in the wrong direction or a swap missing one half changes memory in a visible way. A compare run over a region that was just copied gives a full match, which separates a correct match from an early abort. A compare with length 0 whose first three bytes match shows both the 65536 meaning and the exact residual count at the abort point. An expansion base near the top of the 512K range shows address masking together with the unmasked write-back. Deferred starts, stray trigger pulses and writes during a transfer separate the three start and ignore paths.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_FETCH,
        S_STORE,
        S_FIN
    } xdma_state_t;

    localparam logic [1:0] OP_TO_X = 2'd0;
    localparam logic [1:0] OP_TO_H = 2'd1;
    localparam logic [1:0] OP_SWAP = 2'd2;
    localparam logic [1:0] OP_CMP  = 2'd3;

    localparam int HA_W   = 16;
    localparam int XBUS_W = 24;
    localparam int LEN_W  = 16;
endpackage

// File: rtl/xdma_seq.sv
module xdma_seq
    import xdma_pkg::*;
#(
    parameter int XRAM_AW = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op_in,
    input  logic                 fix_h,
    input  logic                 fix_x,
    input  logic [HA_W-1:0]      h_base,
    input  logic [XBUS_W-1:0]    x_base,
    input  logic [LEN_W-1:0]     len,
    input  logic                 bus_gnt,
    input  logic [7:0]           hb_rdata,
    input  logic [7:0]           xr_rdata,
    output logic                 bus_req,
    output logic [HA_W-1:0]      hb_addr,
    output logic                 hb_re,
    output logic                 hb_we,
    output logic [7:0]           hb_wdata,
    output logic [XRAM_AW-1:0]   xr_addr,
    output logic                 xr_re,
    output logic                 xr_we,
    output logic [7:0]           xr_wdata,
    output logic                 busy,
    output logic                 fin,
    output logic                 mism,
    output logic [HA_W-1:0]      end_h,
    output logic [XBUS_W-1:0]    end_x,
    output logic [LEN_W-1:0]     end_len
);
    localparam int CNT_W = LEN_W + 1;

    xdma_state_t        state, nxt;
    logic [1:0]         op;
    logic [HA_W-1:0]    haddr;
    logic [XBUS_W-1:0]  xaddr;
    logic [CNT_W-1:0]   rem;
    logic               differ;

    assign differ = (op == OP_CMP) && (hb_rdata != xr_rdata);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_REQ;
            S_REQ:   if (bus_gnt) nxt = S_FETCH;
            S_FETCH: nxt = S_STORE;
            S_STORE: nxt = (differ || rem == CNT_W'(1)) ? S_FIN : S_FETCH;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // working counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op    <= OP_TO_X;
            haddr <= '0;
            xaddr <= '0;
            rem   <= '0;
            mism  <= 1'b0;
        end else if (state == S_IDLE && start) begin
            op    <= op_in;
            haddr <= h_base;
            xaddr <= x_base;
            rem   <= (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};
            mism  <= 1'b0;
        end else if (state == S_STORE) begin
            if (differ) begin
                mism <= 1'b1;
            end else begin
                haddr <= haddr + HA_W'(!fix_h);
                xaddr <= xaddr + XBUS_W'(!fix_x);
                rem   <= rem - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bus_req  = (state == S_REQ) || (state == S_FETCH) || (state == S_STORE);
        hb_re    = (state == S_FETCH) && (op != OP_TO_H);
        xr_re    = (state == S_FETCH) && (op != OP_TO_X);
        hb_we    = (state == S_STORE) && (op == OP_TO_H || op == OP_SWAP);
        xr_we    = (state == S_STORE) && (op == OP_TO_X || op == OP_SWAP);
        hb_wdata = xr_rdata;
        xr_wdata = hb_rdata;
        hb_addr  = haddr;
        xr_addr  = xaddr[XRAM_AW-1:0];
        busy     = (state != S_IDLE);
        fin      = (state == S_FIN);
        end_h    = haddr;
        end_x    = xaddr;
        end_len  = rem[LEN_W-1:0];
    end

    // R11
    rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |-> (rem != '0));
    // R14
    store_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STORE) |-> ($past(state) == S_FETCH));
    // R10
    host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STORE && fix_h) |=> $stable(haddr));
    // R14
    access_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |-> $past(bus_gnt));
endmodule

// File: rtl/xdma_regs.sv
module xdma_regs
    import xdma_pkg::*;
#(
    parameter bit BIG_RAM = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               trig,
    input  logic               busy,
    input  logic               fin,
    input  logic               mism,
    input  logic [HA_W-1:0]    end_h,
    input  logic [XBUS_W-1:0]  end_x,
    input  logic [LEN_W-1:0]   end_len,
    output logic               start,
    output logic [1:0]         op_sel,
    output logic               fix_h,
    output logic               fix_x,
    output logic [HA_W-1:0]    h_base,
    output logic [XBUS_W-1:0]  x_base,
    output logic [LEN_W-1:0]   len
);
    localparam int NREG = 16;
    localparam int LAST_RW = 10;
    localparam logic [7:0] ST_RESET = 8'h40 | (BIG_RAM ? 8'h10 : 8'h00);

    logic [7:0] st;
    logic [7:0] rf [1:LAST_RW];
    logic       cmd_wr, imm_go, armed_go;

    assign cmd_wr   = reg_wr && !busy && (reg_sel == 4'd1);
    assign imm_go   = cmd_wr && reg_wdata[7] && reg_wdata[4];
    assign armed_go = trig && rf[1][7] && !rf[1][4];
    assign start    = !busy && (imm_go || armed_go);
    assign op_sel   = cmd_wr ? reg_wdata[1:0] : rf[1][1:0];
    assign fix_h    = rf[10][7];
    assign fix_x    = rf[10][6];
    assign h_base   = {rf[3], rf[2]};
    assign x_base   = {rf[6], rf[5], rf[4]};
    assign len      = {rf[8], rf[7]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_RESET;
            for (int i = 1; i <= LAST_RW; i++) rf[i] <= 8'h00;
        end else begin
            if (reg_rd && reg_sel == 4'd0) st[7:5] <= 3'b000;
            if (reg_wr && !busy) begin
                for (int i = 1; i <= LAST_RW; i++)
                    if (reg_sel == 4'(i)) rf[i] <= reg_wdata;
            end
            if (fin) begin
                st[6]    <= 1'b1;
                if (mism) st[5] <= 1'b1;
                rf[1][7] <= 1'b0;
                if (!rf[1][5]) begin
                    rf[2] <= end_h[7:0];
                    rf[3] <= end_h[15:8];
                    rf[4] <= end_x[7:0];
                    rf[5] <= end_x[15:8];
                    rf[6] <= end_x[23:16];
                    rf[7] <= end_len[7:0];
                    rf[8] <= end_len[15:8];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = 8'hFF;
        for (int i = 1; i <= LAST_RW; i++)
            if (reg_sel == 4'(i)) reg_rdata = rf[i];
        case (reg_sel)
            4'd0:    reg_rdata = st;
            4'd6:    reg_rdata = rf[6] | 8'hF8;
            4'd9:    reg_rdata = rf[9] | 8'h1F;
            4'd10:   reg_rdata = rf[10] | 8'h3F;
            default: ;
        endcase
        if (reg_sel > 4'(LAST_RW) && reg_sel <= 4'(NREG - 1)) reg_rdata = 8'hFF;
    end

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R13
    fin_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (st[6] && !rf[1][7] && !busy));
    // R2
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 4'd0 && !fin) |=> (st[7:5] == 3'b000));
    // R13
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable({rf[2], rf[3], rf[4], rf[5], rf[6], rf[7], rf[8], rf[10]}));
    // R2
    size_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st[4] == BIG_RAM);
endmodule

// File: rtl/xram_dma.sv
module xram_dma
    import xdma_pkg::*;
#(
    parameter int XRAM_AW = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               trig,
    output logic               busy,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [15:0]        hb_addr,
    output logic               hb_re,
    output logic               hb_we,
    output logic [7:0]         hb_wdata,
    input  logic [7:0]         hb_rdata,
    output logic [XRAM_AW-1:0] xr_addr,
    output logic               xr_re,
    output logic               xr_we,
    output logic [7:0]         xr_wdata,
    input  logic [7:0]         xr_rdata
);
    localparam bit BIG_RAM = (XRAM_AW > 17);

    logic               start, fix_h, fix_x, fin, mism;
    logic [1:0]         op_sel;
    logic [HA_W-1:0]    h_base, end_h;
    logic [XBUS_W-1:0]  x_base, end_x;
    logic [LEN_W-1:0]   len, end_len;

    xdma_regs #(.BIG_RAM(BIG_RAM)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig(trig), .busy(busy), .fin(fin), .mism(mism),
        .end_h(end_h), .end_x(end_x), .end_len(end_len),
        .start(start), .op_sel(op_sel), .fix_h(fix_h), .fix_x(fix_x),
        .h_base(h_base), .x_base(x_base), .len(len)
    );

    xdma_seq #(.XRAM_AW(XRAM_AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .op_in(op_sel), .fix_h(fix_h), .fix_x(fix_x),
        .h_base(h_base), .x_base(x_base), .len(len),
        .bus_gnt(bus_gnt), .hb_rdata(hb_rdata), .xr_rdata(xr_rdata),
        .bus_req(bus_req), .hb_addr(hb_addr), .hb_re(hb_re), .hb_we(hb_we),
        .hb_wdata(hb_wdata), .xr_addr(xr_addr), .xr_re(xr_re), .xr_we(xr_we),
        .xr_wdata(xr_wdata), .busy(busy), .fin(fin), .mism(mism),
        .end_h(end_h), .end_x(end_x), .end_len(end_len)
    );
endmodule

// File: tb/sim_xram_dma.sv
module sim_xram_dma;
    localparam int CLK_P = 10;
    localparam int XAW = 19;
    localparam int XMASK = (1 << XAW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] reg_sel = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0, trig = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic busy, bus_req, hb_re, hb_we, xr_re, xr_we;
    logic bus_gnt = 1'b0;
    logic [15:0] hb_addr;
    logic [7:0] hb_wdata, xr_wdata;
    logic [7:0] hb_rdata = '0, xr_rdata = '0;
    logic [XAW-1:0] xr_addr;

    int checks = 0, errors = 0, proto_bad = 0;
    int gwait = 0, gcnt = 0;
    bit finished = 0;

    logic [7:0] hmem [int];
    logic [7:0] xmem [int];
    logic [7:0] eh [int];
    logic [7:0] ex [int];

    always #(CLK_P/2) clk = ~clk;

    xram_dma #(.XRAM_AW(XAW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig), .busy(busy),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .hb_addr(hb_addr), .hb_re(hb_re),
        .hb_we(hb_we), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .xr_addr(xr_addr),
        .xr_re(xr_re), .xr_we(xr_we), .xr_wdata(xr_wdata), .xr_rdata(xr_rdata)
    );

    function automatic logic [7:0] hinit(int a);
        return 8'(a ^ (a >> 8) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] xinit(int a);
        return 8'(a * 7 + 3);
    endfunction
    function automatic logic [7:0] hget(int a);
        return hmem.exists(a) ? hmem[a] : hinit(a);
    endfunction
    function automatic logic [7:0] xget(int a);
        return xmem.exists(a) ? xmem[a] : xinit(a);
    endfunction
    function automatic logic [7:0] ehget(int a);
        return eh.exists(a) ? eh[a] : hinit(a);
    endfunction
    function automatic logic [7:0] exget(int a);
        return ex.exists(a) ? ex[a] : xinit(a);
    endfunction

    // memory and bus models, R14 protocol watch
    always @(posedge clk) begin
        if (hb_re) hb_rdata <= hget(int'(hb_addr));
        if (hb_we) hmem[int'(hb_addr)] = hb_wdata;
        if (xr_re) xr_rdata <= xget(int'(xr_addr));
        if (xr_we) xmem[int'(xr_addr)] = xr_wdata;
        if ((hb_re || hb_we) && !bus_gnt) proto_bad++;
        if (hb_re && hb_we) proto_bad++;
        if (bus_req && !busy) proto_bad++;
        if (!bus_req) begin bus_gnt <= 1'b0; gcnt <= 0; end
        else if (gcnt >= gwait) bus_gnt <= 1'b1;
        else gcnt <= gcnt + 1;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] v);
        @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] v);
        @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic cmp_mems(string req);
        bit ok = 1;
        int bad = 0;
        foreach (eh[k]) if (hget(k) != eh[k]) begin ok = 0; bad = k; end
        foreach (hmem[k]) if (hmem[k] != ehget(k)) begin ok = 0; bad = k; end
        chk(ok, {req, " host memory"}, int'(hget(bad)), int'(ehget(bad)));
        ok = 1; bad = 0;
        foreach (ex[k]) if (xget(k) != ex[k]) begin ok = 0; bad = k; end
        foreach (xmem[k]) if (xmem[k] != exget(k)) begin ok = 0; bad = k; end
        chk(ok, {req, " expansion memory"}, int'(xget(bad)), int'(exget(bad)));
    endtask

    task automatic xfer(input logic [1:0] op, input logic [15:0] h, input logic [23:0] x,
                        input logic [15:0] len, input bit fh, input bit fx, input bit al,
                        input bit defer, input bit poke, input string tag);
        logic [7:0] v, cmd;
        int L, hh, xx, rem, xa;
        bit mm;
        logic [7:0] hv, xv;
        gwait = int'($urandom_range(0, 3));
        rd(4'd0, v);
        wr(4'd2, h[7:0]);  wr(4'd3, h[15:8]);
        wr(4'd4, x[7:0]);  wr(4'd5, x[15:8]); wr(4'd6, x[23:16]);
        wr(4'd7, len[7:0]); wr(4'd8, len[15:8]);
        wr(4'd10, {fh, fx, 6'b0});
        eh = hmem; ex = xmem;
        L = (len == 16'd0) ? 65536 : int'(len);
        hh = int'(h); xx = int'(x); rem = L; mm = 0;
        for (int i = 0; i < L; i++) begin
            xa = xx & XMASK;
            hv = ehget(hh); xv = exget(xa);
            if (op == 2'd0) ex[xa] = hv;
            else if (op == 2'd1) eh[hh] = xv;
            else if (op == 2'd2) begin eh[hh] = xv; ex[xa] = hv; end
            else if (hv != xv) begin mm = 1; break; end
            hh = (hh + (fh ? 0 : 1)) & 16'hFFFF;
            xx = (xx + (fx ? 0 : 1)) & 24'hFFFFFF;
            rem--;
        end
        cmd = {1'b1, 1'b0, al, !defer, 2'b00, op};
        wr(4'd1, cmd);
        if (defer) begin
            // R5: armed command alone does not start
            chk(busy == 1'b0, "R5 armed without trigger", int'(busy), 0);
            pulse_trig();
        end
        // R4: busy in the cycle after the start
        chk(busy == 1'b1, "R4 busy after start", int'(busy), 1);
        if (poke) begin
            wr(4'd2, 8'hA5);
            wr(4'd10, 8'h00);
        end
        while (busy) @(negedge clk);
        cmp_mems(tag);
        // R13 R9: status after completion
        rd(4'd0, v);
        chk(v == (8'h50 | (mm ? 8'h20 : 8'h00)), {tag, " R13 status"}, int'(v),
            int'(8'h50 | (mm ? 8'h20 : 8'h00)));
        rd(4'd1, v);
        chk(v == (cmd & 8'h7F), "R13 command execute cleared", int'(v), int'(cmd & 8'h7F));
        if (al) begin hh = int'(h); xx = int'(x); rem = int'(len); end
        // R12: write-back or keep
        rd(4'd2, v); chk(v == 8'(hh), {tag, " R12 host lo"}, int'(v), hh & 255);
        rd(4'd3, v); chk(v == 8'(hh >> 8), {tag, " R12 host hi"}, int'(v), (hh >> 8) & 255);
        rd(4'd4, v); chk(v == 8'(xx), {tag, " R12 xram lo"}, int'(v), xx & 255);
        rd(4'd5, v); chk(v == 8'(xx >> 8), {tag, " R12 xram mid"}, int'(v), (xx >> 8) & 255);
        rd(4'd6, v); chk(v == (8'(xx >> 16) | 8'hF8), {tag, " R12 xram hi"}, int'(v),
                         int'(8'(xx >> 16) | 8'hF8));
        rd(4'd7, v); chk(v == 8'(rem), {tag, " R12 length lo"}, int'(v), rem & 255);
        rd(4'd8, v); chk(v == 8'(rem >> 8), {tag, " R12 length hi"}, int'(v), (rem >> 8) & 255);
        rd(4'd10, v); chk(v == ({fh, fx, 6'b0} | 8'h3F), "R13 control kept", int'(v),
                          int'({fh, fx, 6'b0} | 8'h3F));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_r;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image
        for (int i = 0; i < 16; i++) begin
            if (i == 0) exp_r = 8'h50;
            else if (i == 6) exp_r = 8'hF8;
            else if (i == 9) exp_r = 8'h1F;
            else if (i == 10) exp_r = 8'h3F;
            else if (i >= 11) exp_r = 8'hFF;
            else exp_r = 8'h00;
            rd(4'(i), v);
            chk(v == exp_r, $sformatf("R1 reg %0d", i), int'(v), int'(exp_r));
        end
        // R2: bit 6 cleared by the read above, bit 4 kept
        rd(4'd0, v); chk(v == 8'h10, "R2 status after read", int'(v), 8'h10);

        // R3: ignored writes and padded reads
        wr(4'd0, 8'hFF); rd(4'd0, v); chk(v == 8'h10, "R3 status write ignored", int'(v), 8'h10);
        for (int i = 11; i < 16; i++) begin
            wr(4'(i), 8'h00); rd(4'(i), v);
            chk(v == 8'hFF, $sformatf("R3 reg %0d write ignored", i), int'(v), 8'hFF);
        end
        wr(4'd9, 8'h40); rd(4'd9, v); chk(v == 8'h5F, "R3 reg 9 padding", int'(v), 8'h5F);
        wr(4'd6, 8'h02); rd(4'd6, v); chk(v == 8'hFA, "R3 reg 6 padding", int'(v), 8'hFA);
        wr(4'd10, 8'h80); rd(4'd10, v); chk(v == 8'hBF, "R3 reg 10 padding", int'(v), 8'hBF);

        // R5: trigger without armed command
        wr(4'd1, 8'h00); pulse_trig();
        chk(busy == 1'b0, "R5 trigger ignored when not armed", int'(busy), 0);

        // R6 then R9 full match over the copied region
        xfer(2'd0, 16'h1000, 24'h000200, 16'd8, 0, 0, 0, 0, 0, "R6 copy");
        xfer(2'd3, 16'h1000, 24'h000200, 16'd8, 0, 0, 0, 0, 0, "R9 match");
        // R5: trigger after completion does nothing (execute cleared)
        pulse_trig();
        chk(busy == 1'b0, "R5 trigger after completion ignored", int'(busy), 0);
        // R11: length 0 compare, first three bytes equal
        xfer(2'd0, 16'h3000, 24'h000100, 16'd3, 0, 0, 1, 0, 0, "R6 prefix");
        xfer(2'd3, 16'h3000, 24'h000100, 16'd0, 0, 0, 0, 0, 0, "R11 zero length");
        // R6: expansion address masked to size, unmasked write-back
        xfer(2'd0, 16'hFFFE, 24'h07FFFE, 16'd4, 0, 0, 0, 0, 0, "R6 wrap");
        // R7, R8, R10, deferred start and writes while busy (R13)
        xfer(2'd1, 16'h4000, 24'h010000, 16'd6, 0, 0, 0, 1, 0, "R7 deferred");
        xfer(2'd2, 16'h5000, 24'h020000, 16'd5, 1, 1, 0, 0, 0, "R10 swap both fixed");
        xfer(2'd2, 16'h5100, 24'h020100, 16'd7, 0, 0, 1, 0, 1, "R8 swap poke");
        xfer(2'd0, 16'h6000, 24'h030000, 16'd5, 0, 1, 0, 1, 1, "R10 xram fixed");

        for (int n = 0; n < 24; n++) begin
            logic [1:0] op;
            bit fh, fx;
            string t;
            op = 2'($urandom_range(0, 3));
            fh = ($urandom_range(0, 3) == 0);
            fx = ($urandom_range(0, 3) == 0);
            if (fh || fx) t = "R10 random";
            else if (op == 2'd0) t = "R6 random";
            else if (op == 2'd1) t = "R7 random";
            else if (op == 2'd2) t = "R8 random";
            else t = "R9 random";
            xfer(op, 16'($urandom_range(0, 65535)), 24'($urandom_range(0, 24'hFFFFFF)),
                 16'($urandom_range(1, 24)), fh, fx, bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), t);
        end

        // R14: bus protocol observed throughout
        chk(proto_bad == 0, "R14 bus protocol", proto_bad, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule